// File: doc/BRIEF.md
# Pin-Driven Phase Step Controller

This block turns pulses on two control pins into phase-offset updates for a set of output channels. One pin raises the phase and the other lowers it. A pulse counts only when the pin stays high for a minimum number of system-clock cycles and then stays low for a minimum number of cycles. After an update is accepted, the pins are ignored for a guard interval. This caps the update rate at about 1.5 MHz.

Each channel has its own participation enable and its own step size, counted in 20 ps units. Its offset is a signed value kept within ±2250 units, which is ±45 ns. A channel takes part in a step only when its enable is set and its spread-spectrum status input is clear. A requested step first changes a target value. The visible offset copies that target only on the channel's output-period boundary, so a phase change never cuts an output period short.

A decrement can be illegal: it would bring some participating channel's synthesizer period below a minimum number of VCO periods. That channel's period is supplied as a count input. On an illegal decrement the block drops the step, blanks all outputs for a fixed number of output periods, and keeps every offset at its value from before the request.

Top module: `phase_step_ctrl`

## Requirements
- R1: A pin request is recognised only after the two-flop-synchronised pin is high for at least MIN_HI cycles and then low for at least MIN_LO cycles. A high phase that is too short, or a low phase cut short by a new high, produces no request.
- R2: Once a request has been accepted, any request recognised within the next GAP cycles is ignored.
- R3: An increment adds the channel's step to its target and a decrement subtracts it, for each channel whose enable bit is 1. The step is the unsigned field `ch_step[i*STEP_W +: STEP_W]`. Channels with enable 0 keep their value.
- R4: Each offset is two's complement in `phase_ofs[i*OFS_W +: OFS_W]` and stays within ±LIMIT (2250 by default). A step past either bound leaves the value at that bound.
- R5: A channel whose `ss_active` bit is 1 ignores step requests.
- R6: A decrement is illegal when, for any participating channel, `period_vco*UNITS_PER_VCO < step + MIN_VCO*UNITS_PER_VCO`. An illegal decrement:
  - changes no offset;
  - drives `out_en` low until BLANK_PER pulses of `per_tick[0]` have been seen;
  - causes every request during that blanking to be ignored.
- R7: A channel's `phase_ofs` field changes only on a cycle after its `per_tick` bit was 1. At that point it takes the pending target.
- R8: After reset, all offsets are 0, `out_en` is 1 and all saturation flags are 0.
- R9: A saturating step sets that channel's `sat_flag` bit. The bit stays set until reset.
- R10: If increment and decrement requests are recognised in the same cycle, neither one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_pin | input | 1 | Phase increment pin (asynchronous) |
| dec_pin | input | 1 | Phase decrement pin (asynchronous) |
| ch_en | input | NUM_CH | Per-channel participation enable |
| ss_active | input | NUM_CH | Per-channel spread-spectrum status |
| ch_step | input | NUM_CH*STEP_W | Per-channel step magnitude, 20 ps units |
| period_vco | input | NUM_CH*PER_W | Per-channel synthesizer period in VCO periods |
| per_tick | input | NUM_CH | Per-channel output period boundary strobe |
| phase_ofs | output | NUM_CH*OFS_W | Applied signed offsets |
| sat_flag | output | NUM_CH | Sticky saturation flags |
| out_en | output | 1 | Output enable; low while blanking |

## Verification
Two cases can fall in the same cycle. In the first, increment and decrement qualify together: the bench drives both pins with the same waveform, so both qualifiers strobe on the same edge, and it checks that no offset moves after a boundary tick. In the second, a new request meets the guard interval or a blanking window. The bench sends a second pulse before the guard has run out, and an increment pulse during blanking. It checks that only the first step lands and that blanking ends on exactly the tenth boundary.

// File: rtl/psc_pkg.sv
package psc_pkg;
   // index of each control pin in the internal pin vector
   localparam int PIN_UP   = 0;
   localparam int PIN_DOWN = 1;
   localparam int NUM_PINS = 2;

   typedef struct packed {
      logic up;
      logic down;
   } step_req_t;
endpackage

// File: rtl/psc_pin_qual.sv
module psc_pin_qual #(
   parameter int MIN_HI = 6,
   parameter int MIN_LO = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic strobe
);
   localparam int MAXC = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
   localparam int CW   = $clog2(MAXC + 1);

   logic [1:0]    sync_q;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] lo_cnt;
   logic          armed;
   logic          lvl;
   logic          hi_ok;
   logic          lo_phase;

   assign lvl      = sync_q[1];
   assign hi_ok    = (hi_cnt == CW'(MIN_HI));
   assign lo_phase = armed | hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         hi_cnt <= '0;
         lo_cnt <= '0;
         armed  <= 1'b0;
         strobe <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], pin};
         strobe <= 1'b0;
         if (lvl) begin
            hi_cnt <= hi_ok ? hi_cnt : hi_cnt + 1'b1;
            lo_cnt <= '0;
            armed  <= 1'b0;
         end else begin
            hi_cnt <= '0;
            if (lo_phase) begin
               if (lo_cnt == CW'(MIN_LO - 1)) begin
                  strobe <= 1'b1;
                  armed  <= 1'b0;
                  lo_cnt <= '0;
               end else begin
                  armed  <= 1'b1;
                  lo_cnt <= lo_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/psc_channel.sv
module psc_channel #(
   parameter int OFS_W   = 13,
   parameter int STEP_W  = 8,
   parameter int PER_W   = 8,
   parameter int LIMIT   = 2250,
   parameter int UPV     = 20,
   parameter int MIN_VCO = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    ss,
   input  logic [STEP_W-1:0]       step,
   input  logic [PER_W-1:0]        period,
   input  logic                    up_go,
   input  logic                    down_go,
   input  logic                    tick,
   output logic signed [OFS_W-1:0] ofs,
   output logic signed [OFS_W-1:0] tgt,
   output logic                    sat,
   output logic                    illegal
);
   localparam int SW  = OFS_W + 1;
   localparam int PUW = 32;
   localparam logic signed [SW-1:0] LIM_P = SW'(LIMIT);
   localparam logic signed [SW-1:0] LIM_N = -LIM_P;

   logic                 part;
   logic signed [SW-1:0] wide;
   logic signed [SW-1:0] stp_s;
   logic signed [SW-1:0] up_v;
   logic signed [SW-1:0] dn_v;
   logic [PUW-1:0]       per_units;
   logic [PUW-1:0]       floor_units;

   assign part        = en & ~ss;
   assign wide        = {tgt[OFS_W-1], tgt};
   assign stp_s       = SW'($signed({1'b0, step}));
   assign up_v        = wide + stp_s;
   assign dn_v        = wide - stp_s;
   assign per_units   = PUW'(period) * PUW'(UPV);
   assign floor_units = PUW'(step) + PUW'(MIN_VCO * UPV);
   assign illegal     = part & (per_units < floor_units);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt <= '0;
         ofs <= '0;
         sat <= 1'b0;
      end else begin
         if (tick) ofs <= tgt;
         if (part && up_go) begin
            if (up_v > LIM_P) begin
               tgt <= LIM_P[OFS_W-1:0];
               sat <= 1'b1;
            end else begin
               tgt <= up_v[OFS_W-1:0];
            end
         end else if (part && down_go) begin
            if (dn_v < LIM_N) begin
               tgt <= LIM_N[OFS_W-1:0];
               sat <= 1'b1;
            end else begin
               tgt <= dn_v[OFS_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/psc_blank.sv
module psc_blank #(
   parameter int BLANK_PER = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic out_en
);
   localparam int BW = $clog2(BLANK_PER + 1);

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en <= 1'b1;
         cnt    <= '0;
      end else if (start) begin
         out_en <= 1'b0;
         cnt    <= '0;
      end else if (!out_en && tick) begin
         if (cnt == BW'(BLANK_PER - 1)) begin
            out_en <= 1'b1;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
   import psc_pkg::*;
#(
   parameter int NUM_CH        = 4,
   parameter int OFS_W         = 13,
   parameter int STEP_W        = 8,
   parameter int PER_W         = 8,
   parameter int LIMIT         = 2250,
   parameter int UNITS_PER_VCO = 20,
   parameter int MIN_VCO       = 8,
   parameter int MIN_HI        = 6,
   parameter int MIN_LO        = 6,
   parameter int GAP           = 34,
   parameter int BLANK_PER     = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inc_pin,
   input  logic                     dec_pin,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH-1:0]        ss_active,
   input  logic [NUM_CH*STEP_W-1:0] ch_step,
   input  logic [NUM_CH*PER_W-1:0]  period_vco,
   input  logic [NUM_CH-1:0]        per_tick,
   output logic [NUM_CH*OFS_W-1:0]  phase_ofs,
   output logic [NUM_CH-1:0]        sat_flag,
   output logic                     out_en
);
   localparam int CLW = $clog2(GAP + 1);

   if (LIMIT >= 2**(OFS_W-1)) begin : g_bad_limit
      $error("LIMIT does not fit the signed offset width");
   end
   if (STEP_W >= OFS_W) begin : g_bad_step
      $error("STEP_W must be narrower than OFS_W");
   end
   if (GAP < 2 || MIN_HI < 1 || MIN_LO < 1 || BLANK_PER < 1) begin : g_bad_timing
      $error("timing parameters out of range");
   end

   logic [NUM_PINS-1:0]    pins;
   logic [NUM_PINS-1:0]    strobes;
   step_req_t              req;
   logic                   single;
   logic                   go;
   logic                   up_go;
   logic                   down_try;
   logic                   down_go;
   logic                   blank_start;
   logic                   illegal_any;
   logic [NUM_CH-1:0]      ch_illegal;
   logic [NUM_CH*OFS_W-1:0] tgt_flat;
   logic [CLW-1:0]         cool;

   assign pins[PIN_UP]   = inc_pin;
   assign pins[PIN_DOWN] = dec_pin;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      psc_pin_qual #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pins[p]),
         .strobe(strobes[p])
      );
   end

   assign req.up      = strobes[PIN_UP];
   assign req.down    = strobes[PIN_DOWN];
   assign single      = req.up ^ req.down;
   assign go          = single & (cool == '0) & out_en;
   assign up_go       = go & req.up;
   assign down_try    = go & req.down;
   assign illegal_any = |ch_illegal;
   assign down_go     = down_try & ~illegal_any;
   assign blank_start = down_try & illegal_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cool <= '0;
      else if (go)          cool <= CLW'(GAP - 1);
      else if (cool != '0)  cool <= cool - 1'b1;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      psc_channel #(
         .OFS_W(OFS_W), .STEP_W(STEP_W), .PER_W(PER_W), .LIMIT(LIMIT),
         .UPV(UNITS_PER_VCO), .MIN_VCO(MIN_VCO)
      ) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (ch_en[i]),
         .ss     (ss_active[i]),
         .step   (ch_step[i*STEP_W +: STEP_W]),
         .period (period_vco[i*PER_W +: PER_W]),
         .up_go  (up_go),
         .down_go(down_go),
         .tick   (per_tick[i]),
         .ofs    (phase_ofs[i*OFS_W +: OFS_W]),
         .tgt    (tgt_flat[i*OFS_W +: OFS_W]),
         .sat    (sat_flag[i]),
         .illegal(ch_illegal[i])
      );
   end

   psc_blank #(.BLANK_PER(BLANK_PER)) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .start (blank_start),
      .tick  (per_tick[0]),
      .out_en(out_en)
   );
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
   parameter int NUM_CH = 4,
   parameter int OFS_W  = 13,
   parameter int LIMIT  = 2250,
   parameter int GAP    = 34
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH-1:0]       per_tick,
   input logic [NUM_CH*OFS_W-1:0] phase_ofs,
   input logic [NUM_CH*OFS_W-1:0] tgt_flat,
   input logic [NUM_CH-1:0]       sat_flag,
   input logic                    out_en,
   input logic                    up_s,
   input logic                    down_s,
   input logic                    go
);
   int since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         since <= GAP;
      else if (go)        since <= 1;
      else if (since < GAP) since <= since + 1;
   end

   p_rate_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> since >= GAP);

   p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> $stable(tgt_flat));

   p_both_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_s && down_s) |=> $stable(tgt_flat));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      p_ofs_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (int'($signed(phase_ofs[i*OFS_W +: OFS_W])) <= LIMIT) &&
         (int'($signed(phase_ofs[i*OFS_W +: OFS_W])) >= -LIMIT));

      p_glitchless_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !per_tick[i] |=> $stable(phase_ofs[i*OFS_W +: OFS_W]));

      p_sat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sat_flag[i] |=> sat_flag[i]);
   end
endmodule

bind phase_step_ctrl psc_chk #(
   .NUM_CH(NUM_CH), .OFS_W(OFS_W), .LIMIT(LIMIT), .GAP(GAP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .per_tick (per_tick),
   .phase_ofs(phase_ofs),
   .tgt_flat (tgt_flat),
   .sat_flag (sat_flag),
   .out_en   (out_en),
   .up_s     (req.up),
   .down_s   (req.down),
   .go       (go)
);

// File: tb/test_phase_step_ctrl.sv
module test_phase_step_ctrl;
   localparam int NCH = 4;
   localparam int OW  = 13;
   localparam int SWD = 8;
   localparam int PW  = 8;
   localparam int LIM = 2250;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             inc_pin = 1'b0;
   logic             dec_pin = 1'b0;
   logic [NCH-1:0]   ch_en = '1;
   logic [NCH-1:0]   ss_active = '0;
   logic [NCH*SWD-1:0] ch_step;
   logic [NCH*PW-1:0]  period_vco;
   logic [NCH-1:0]   per_tick = '0;
   logic [NCH*OW-1:0] phase_ofs;
   logic [NCH-1:0]   sat_flag;
   logic             out_en;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;
   int exp_ofs[NCH];
   bit exp_sat[NCH];
   int steps[NCH] = '{10, 100, 255, 1};

   always #10 clk = ~clk;

   phase_step_ctrl i_phase_step_ctrl (
      .clk(clk), .rst_n(rst_n), .inc_pin(inc_pin), .dec_pin(dec_pin),
      .ch_en(ch_en), .ss_active(ss_active), .ch_step(ch_step),
      .period_vco(period_vco), .per_tick(per_tick),
      .phase_ofs(phase_ofs), .sat_flag(sat_flag), .out_en(out_en)
   );

   task automatic chk(string req, int act, int expv);
      nchk++;
      if (act != expv) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic check_all(string req);
      for (int c = 0; c < NCH; c++) begin
         chk(req, int'($signed(phase_ofs[c*OW +: OW])), exp_ofs[c]);
         chk(req, int'(sat_flag[c]), int'(exp_sat[c]));
      end
   endtask

   task automatic model(bit up);
      for (int c = 0; c < NCH; c++) begin
         if (ch_en[c] && !ss_active[c]) begin
            int v = up ? exp_ofs[c] + steps[c] : exp_ofs[c] - steps[c];
            if (v > LIM)  begin v = LIM;  exp_sat[c] = 1; end
            if (v < -LIM) begin v = -LIM; exp_sat[c] = 1; end
            exp_ofs[c] = v;
         end
      end
   endtask

   task automatic pulse(bit i, bit d, int hi, int lo);
      @(negedge clk); inc_pin = i; dec_pin = d;
      repeat (hi) @(negedge clk);
      inc_pin = 0; dec_pin = 0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic settle();
      repeat (40) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk); per_tick = '1;
      @(negedge clk); per_tick = '0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check_all("R8 reset offsets/flags");
      chk("R8 reset out_en", int'(out_en), 1);
   endtask

   task automatic t_inc_dec();
      pulse(1, 0, 8, 8); settle();
      check_all("R7 no change before boundary");
      model(1); tick();
      check_all("R3 increment applied");
      pulse(0, 1, 8, 8); settle();
      model(0); tick();
      check_all("R3 decrement applied");
   endtask

   task automatic t_short();
      pulse(1, 0, 3, 20); settle(); tick();
      check_all("R1 short high ignored");
      pulse(1, 0, 8, 3);
      pulse(1, 0, 3, 20); settle(); tick();
      check_all("R1 short low ignored");
   endtask

   task automatic t_rate();
      pulse(1, 0, 8, 8);
      pulse(1, 0, 8, 8);
      settle();
      model(1); tick();
      check_all("R2 second request in guard ignored");
   endtask

   task automatic t_en_ss();
      ch_en = 4'b1110; ss_active = 4'b1000;
      pulse(1, 0, 8, 8); settle();
      model(1); tick();
      check_all("R3 R5 disabled and spread channels hold");
      ch_en = '1; ss_active = '0;
      settle();
   endtask

   task automatic t_both();
      pulse(1, 1, 8, 8); settle(); tick();
      check_all("R10 simultaneous requests dropped");
   endtask

   task automatic t_sat();
      for (int k = 0; k < 10; k++) begin
         pulse(1, 0, 8, 8); settle(); model(1);
      end
      tick();
      check_all("R4 R9 saturation at limit, sticky flag");
      pulse(0, 1, 8, 8); settle(); model(0); tick();
      check_all("R9 flag stays after leaving limit");
   endtask

   task automatic t_illegal();
      period_vco[1*PW +: PW] = 8'd12;
      pulse(0, 1, 8, 8); settle();
      chk("R6 blanking starts", int'(out_en), 0);
      pulse(1, 0, 8, 8); settle();
      for (int k = 0; k < 9; k++) tick();
      chk("R6 still blanked after 9 periods", int'(out_en), 0);
      check_all("R6 offsets kept, request in blank ignored");
      tick();
      chk("R6 outputs back after 10 periods", int'(out_en), 1);
      period_vco[1*PW +: PW] = 8'd40;
      settle();
      pulse(0, 1, 8, 8); settle(); model(0); tick();
      check_all("R6 legal decrement after recovery");
      chk("R6 out_en after legal decrement", int'(out_en), 1);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         ch_step[c*SWD +: SWD]   = SWD'(steps[c]);
         period_vco[c*PW +: PW]  = 8'd40;
         exp_ofs[c] = 0; exp_sat[c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_inc_dec();
      t_short();
      t_rate();
      t_en_ss();
      t_both();
      t_sat();
      t_illegal();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end
endmodule